// File: doc/BRIEF.md
# Variable-Stride State-Variable Filter Stepper

This block advances the three integrator states of a two-integrator-loop filter (highpass, bandpass, lowpass) across an arbitrary number of elapsed sample cycles in a single request. The caller pulses `start` together with an elapsed-cycle count, the routed filter input, a cutoff step coefficient and an inverse-resonance coefficient. The block then walks through the count in strides of no more than eight cycles, one stride per clock. For each stride it scales the cutoff coefficient by the stride length and applies one integrator update.

When the last stride has been applied, `busy` falls and `done` pulses. A request made while the filter is disabled clears all three states. A request with a count of zero completes at once and leaves the states unchanged. The input sample and both coefficients are captured when a request is accepted, so the caller may change them while the block is working.

Top module: `filter_step_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `vhp`, `vbp` and `vlp` are all 0.
- R2: An accepted enabled request with count N > 0 applies one stride per clock. Each stride covers min(remaining, 8) cycles, so `busy` is high for exactly ceil(N/8) clock cycles, starting the cycle after `start` is sampled.
- R3: For each stride of length L, the effective coefficient is (coef_step × L) >> 6, with the low bits discarded.
- R4: For each stride, the bandpass state becomes vbp − ((eff × vhp) >>> 14) and the lowpass state becomes vlp − ((eff × vbp) >>> 14). Both use the values held before the stride, with an arithmetic shift. Results wrap to the state width.
- R5: After each stride, the highpass state becomes ((new vbp × inv_q) >>> 10) − new vlp − vin, wrapped to the state width.
- R6: `done` is high for exactly one cycle. That cycle is the one in which `busy` is first low after the final stride, and the final states are visible in it.
- R7: An enabled request with a count of zero raises `done` the next cycle, never raises `busy`, and leaves all three states unchanged.
- R8: A request taken while `filt_en` is 0 performs no strides. In the next cycle all three states read 0 and `done` is 1.
- R9: A `start` that arrives while `busy` is high is ignored, including one in the cycle of the final stride. `busy` stays low once the current request has finished.
- R10: `vin`, `coef_step` and `inv_q` are sampled only when a request is accepted. Changing them while busy does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when not busy |
| delta_t | input | DT_W | Elapsed cycle count for the request |
| filt_en | input | 1 | Filter enable; 0 makes a request clear the states |
| vin | input | SW | Routed filter input sample (signed) |
| coef_step | input | CW | Cutoff step coefficient (unsigned) |
| inv_q | input | CW | Inverse-resonance coefficient, 1.0 = 1024 (unsigned) |
| busy | output | 1 | High while strides remain |
| done | output | 1 | One-cycle completion pulse |
| vhp | output | SW | Highpass state (signed) |
| vbp | output | SW | Bandpass state (signed) |
| vlp | output | SW | Lowpass state (signed) |

## Verification
A new `start` and the final stride of a running request can land in the same cycle. The bench forces this by raising `start` at the last busy cycle, with different inputs and a non-zero count. It then requires that `busy` stays low after `done`, and that the final states match a model that uses only the original request. A second collision is also exercised: a fresh request is raised mid-run with altered sample and coefficients. The result is compared against a bench-side model that steps the same stride sequence from the captured values.

// File: rtl/fstep_pkg.sv
package fstep_pkg;
    localparam int COEF_SHIFT = 6;
    localparam int INTEG_SHIFT = 14;
    localparam int RESO_SHIFT = 10;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_RUN  = 1'b1
    } fs_state_e;
endpackage

// File: rtl/fs_len_pick.sv
module fs_len_pick #(
    parameter int DT_W     = 16,
    parameter int MAX_STEP = 8,
    parameter int LEN_W    = 4
) (
    input  logic [DT_W-1:0]  remain,
    output logic [LEN_W-1:0] len
);
    always_comb begin
        if (remain >= DT_W'(MAX_STEP)) begin
            len = LEN_W'(MAX_STEP);
        end else begin
            len = remain[LEN_W-1:0];
        end
    end
endmodule

// File: rtl/fs_coef_scale.sv
module fs_coef_scale
    import fstep_pkg::*;
#(
    parameter int CW    = 16,
    parameter int LEN_W = 4,
    parameter int EFF_W = CW + LEN_W - COEF_SHIFT
) (
    input  logic [CW-1:0]    coef,
    input  logic [LEN_W-1:0] len,
    output logic [EFF_W-1:0] eff
);
    localparam int PROD_W = CW + LEN_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(coef) * PROD_W'(len);
        eff  = prod[PROD_W-1:COEF_SHIFT];
    end
endmodule

// File: rtl/fs_integ.sv
module fs_integ
    import fstep_pkg::*;
#(
    parameter int SW    = 20,
    parameter int EFF_W = 14,
    parameter int QW    = 16
) (
    input  logic [EFF_W-1:0]     eff,
    input  logic [QW-1:0]        invq,
    input  logic signed [SW-1:0] hp,
    input  logic signed [SW-1:0] bp,
    input  logic signed [SW-1:0] lp,
    input  logic signed [SW-1:0] vin,
    output logic signed [SW-1:0] hp_n,
    output logic signed [SW-1:0] bp_n,
    output logic signed [SW-1:0] lp_n
);
    localparam int PW = SW + EFF_W + QW + 2;

    logic signed [PW-1:0] eff_w, invq_w;
    logic signed [PW-1:0] dec_bp, dec_lp;
    logic signed [PW-1:0] bp_w, lp_w, q_w, hp_w;

    always_comb begin
        eff_w  = $signed({{(PW-EFF_W){1'b0}}, eff});
        invq_w = $signed({{(PW-QW){1'b0}}, invq});
        dec_bp = (eff_w * PW'(hp)) >>> INTEG_SHIFT;
        dec_lp = (eff_w * PW'(bp)) >>> INTEG_SHIFT;
        bp_w   = PW'(bp) - dec_bp;
        lp_w   = PW'(lp) - dec_lp;
        bp_n   = bp_w[SW-1:0];
        lp_n   = lp_w[SW-1:0];
        q_w    = (PW'(bp_n) * invq_w) >>> RESO_SHIFT;
        hp_w   = q_w - PW'(lp_n) - PW'(vin);
        hp_n   = hp_w[SW-1:0];
    end
endmodule

// File: rtl/filter_step_seq.sv
module filter_step_seq
    import fstep_pkg::*;
#(
    parameter int SW       = 20,
    parameter int CW       = 16,
    parameter int DT_W     = 16,
    parameter int MAX_STEP = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DT_W-1:0]      delta_t,
    input  logic                 filt_en,
    input  logic signed [SW-1:0] vin,
    input  logic [CW-1:0]        coef_step,
    input  logic [CW-1:0]        inv_q,
    output logic                 busy,
    output logic                 done,
    output logic signed [SW-1:0] vhp,
    output logic signed [SW-1:0] vbp,
    output logic signed [SW-1:0] vlp
);
    localparam int LEN_W = $clog2(MAX_STEP + 1);
    localparam int EFF_W = CW + LEN_W - COEF_SHIFT;

    typedef struct packed {
        fs_state_e              st;
        logic                   done;
        logic [DT_W-1:0]        rem;
        logic signed [SW-1:0]   hp;
        logic signed [SW-1:0]   bp;
        logic signed [SW-1:0]   lp;
        logic signed [SW-1:0]   vin;
        logic [CW-1:0]          coef;
        logic [CW-1:0]          invq;
    } regs_t;

    regs_t r_q, r_d;

    logic [LEN_W-1:0]     len;
    logic [EFF_W-1:0]     eff;
    logic signed [SW-1:0] hp_n, bp_n, lp_n;

    fs_len_pick #(.DT_W(DT_W), .MAX_STEP(MAX_STEP), .LEN_W(LEN_W)) u_len (
        .remain (r_q.rem),
        .len    (len)
    );

    fs_coef_scale #(.CW(CW), .LEN_W(LEN_W), .EFF_W(EFF_W)) u_scale (
        .coef (r_q.coef),
        .len  (len),
        .eff  (eff)
    );

    fs_integ #(.SW(SW), .EFF_W(EFF_W), .QW(CW)) u_integ (
        .eff  (eff),
        .invq (r_q.invq),
        .hp   (r_q.hp),
        .bp   (r_q.bp),
        .lp   (r_q.lp),
        .vin  (r_q.vin),
        .hp_n (hp_n),
        .bp_n (bp_n),
        .lp_n (lp_n)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            FS_IDLE: begin
                if (start) begin
                    if (!filt_en) begin
                        r_d.hp   = '0;
                        r_d.bp   = '0;
                        r_d.lp   = '0;
                        r_d.done = 1'b1;
                    end else if (delta_t == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = FS_RUN;
                        r_d.rem  = delta_t;
                        r_d.vin  = vin;
                        r_d.coef = coef_step;
                        r_d.invq = inv_q;
                    end
                end
            end
            FS_RUN: begin
                r_d.hp  = hp_n;
                r_d.bp  = bp_n;
                r_d.lp  = lp_n;
                r_d.rem = r_q.rem - DT_W'(len);
                if (r_q.rem == DT_W'(len)) begin
                    r_d.st   = FS_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: FS_IDLE, done: 1'b0, rem: '0, hp: '0, bp: '0,
                     lp: '0, vin: '0, coef: '0, invq: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st == FS_RUN);
    assign done = r_q.done;
    assign vhp  = r_q.hp;
    assign vbp  = r_q.bp;
    assign vlp  = r_q.lp;

    AST_STEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (($past(r_q.rem) - r_q.rem) <= DT_W'(MAX_STEP))); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && filt_en && delta_t == '0) |=>
        (done && !busy && $stable(vhp) && $stable(vbp) && $stable(vlp))); // R7

    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !filt_en) |=>
        (done && !busy && vhp == '0 && vbp == '0 && vlp == '0)); // R8

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && r_q.rem > DT_W'(MAX_STEP)) |=> busy); // R9

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(r_q.vin) && $stable(r_q.coef) && $stable(r_q.invq))); // R10
endmodule

// File: tb/tb_filter_step_seq.sv
module tb_filter_step_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 20;
    localparam int CW = 16;
    localparam int DT_W = 16;
    localparam int WD_CYCLES = 20000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [DT_W-1:0]      delta_t = '0;
    logic                 filt_en = 1'b1;
    logic signed [SW-1:0] vin = '0;
    logic [CW-1:0]        coef_step = '0;
    logic [CW-1:0]        inv_q = '0;
    logic                 busy, done;
    logic signed [SW-1:0] vhp, vbp, vlp;

    int n_chk = 0;
    int n_bad = 0;
    longint m_hp = 0, m_bp = 0, m_lp = 0;

    filter_step_seq #(.SW(SW), .CW(CW), .DT_W(DT_W), .MAX_STEP(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .delta_t(delta_t),
        .filt_en(filt_en), .vin(vin), .coef_step(coef_step), .inv_q(inv_q),
        .busy(busy), .done(done), .vhp(vhp), .vbp(vbp), .vlp(vlp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected finished)");
        summary();
        $finish;
    end

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint wrap(longint x);
        longint m;
        m = x & ((64'sd1 <<< SW) - 1);
        if (m[SW-1]) m = m - (64'sd1 <<< SW);
        return m;
    endfunction

    // model follows R2..R5 independently
    task automatic model(int dt, longint v, longint c, longint q);
        int rem;
        rem = dt;
        while (rem > 0) begin
            int l;
            longint e, nb, nl;
            l  = (rem < 8) ? rem : 8;
            e  = (c * l) >>> 6;
            nb = wrap(m_bp - ((e * m_hp) >>> 14));
            nl = wrap(m_lp - ((e * m_bp) >>> 14));
            m_bp = nb;
            m_lp = nl;
            m_hp = wrap(((m_bp * q) >>> 10) - m_lp - v);
            rem -= l;
        end
    endtask

    // poke_at > 0: raise start with junk inputs on that busy cycle
    task automatic run(string tag, int dt, int v, int c, int q, bit en, int poke_at);
        int cnt, exp_n;
        @(negedge clk);
        start = 1'b1; delta_t = DT_W'(dt); vin = SW'(v);
        coef_step = CW'(c); inv_q = CW'(q); filt_en = en;
        if (!en) begin m_hp = 0; m_bp = 0; m_lp = 0; exp_n = 0; end
        else begin model(dt, v, c, q); exp_n = (dt + 7) / 8; end
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (busy && cnt < 2000) begin
            cnt++;
            if (cnt == poke_at) begin
                start = 1'b1; delta_t = 16'd3; vin = SW'(v + 777);
                coef_step = CW'(c + 5000); inv_q = CW'(q + 300); filt_en = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk({tag, " R2 busy cycles"}, cnt, exp_n);
        chk({tag, " R6 done raised"}, done, 1);
        chk({tag, " R4 vbp"}, vbp, m_bp);
        chk({tag, " R4 vlp"}, vlp, m_lp);
        chk({tag, " R5 vhp"}, vhp, m_hp);
        @(negedge clk);
        chk({tag, " R6 done one cycle"}, done, 0);
        chk({tag, " R9 idle after"}, busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 vhp", vhp, 0);
        chk("R1 vbp", vbp, 0);
        chk("R1 vlp", vlp, 0);
    endtask

    task automatic t_zero();
        longint h, b, l;
        h = vhp; b = vbp; l = vlp;
        run("R7 zero count", 0, 900, 4000, 1500, 1'b1, 0);
        chk("R7 vhp unchanged", vhp, h);
        chk("R7 vbp unchanged", vbp, b);
        chk("R7 vlp unchanged", vlp, l);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run("R2 single stride", 8, 1000, 3000, 1024, 1'b1, 0);
        run("R3 short stride", 3, 1000, 3000, 1024, 1'b1, 0);
        run("R3 split 13", 13, -800, 5000, 700, 1'b1, 0);
        run("R2 long 100", 100, 1200, 2500, 1400, 1'b1, 0);
        run("R5 resonant", 17, -500, 6000, 300, 1'b1, 0);
        t_zero();
        run("R9 R10 mid poke", 40, 600, 3500, 900, 1'b1, 2);
        run("R9 last-cycle poke", 20, -700, 4200, 1100, 1'b1, 3);
        run("R8 disabled", 30, 500, 3000, 1024, 1'b0, 0);
        chk("R8 vbp cleared", vbp, 0);
        run("R2 after clear", 9, 2000, 8000, 1024, 1'b1, 0);
        summary();
        $finish;
    end
endmodule